// File: doc/BRIEF.md
# Cascadable Nibble Magnitude Comparator

This block compares two unsigned 4-bit words in one combinational slice. Each slice produces three flags: greater, equal and less. A slice also takes three flags from a less significant stage. Those incoming flags only matter when the two nibbles match on every bit. When the nibbles differ, the most significant differing bit pair alone sets the result.

The cascade inputs have defined results for all eight patterns, not only the three one-hot ones:

- With greater and less both set and equal clear, the slice drives all three outputs low.
- With all three flags clear, the slice drives greater and less high together.

These two patterns let a designer build a parallel comparison tree from the slice.

The top module chains a parameterised number of slices in series. Each slice's outputs feed the cascade inputs of the next more significant slice. The least significant slice sees a constant "equal" pattern, so the chain compares two words of 4·NSLICES bits as unsigned weighted values. The slice accepts any monotonic 4-bit code, such as plain binary or BCD digits. There is no clock and no state.

Top module: `nibcmp_chain`

## Requirements
- R1: When the two nibbles differ, the most significant differing bit pair alone sets greater (A bit 1, B bit 0) or less (A bit 0, B bit 1). Equal is 0 and the cascade inputs have no effect. Bit 3 is the most significant.
- R2: On a full nibble tie, cascade input {gt,eq,lt}=100 gives outputs 100, and 001 gives 001.
- R3: On a full nibble tie with the cascade eq input at 1, the outputs are gt=0, eq=1, lt=0 whatever the gt and lt cascade inputs are.
- R4: On a full nibble tie with cascade {gt,eq,lt}=101, all three outputs are 0.
- R5: On a full nibble tie with cascade {gt,eq,lt}=000, the outputs are gt=1, eq=0, lt=1.
- R6: When exactly one cascade input is 1, exactly one output is 1.
- R7: The chain ties the least significant slice to the equal pattern. Its outputs then match the unsigned comparison of the full a_i and b_i words, with bit 4·k+3 the most significant bit of slice k.
- R8: Words made of BCD digits compare by their decimal value, because each digit is compared as an unsigned weighted nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4*NSLICES | First operand, unsigned |
| b_i | input | 4*NSLICES | Second operand, unsigned |
| gt_o | output | 1 | a_i greater than b_i |
| eq_o | output | 1 | a_i equal to b_i |
| lt_o | output | 1 | a_i less than b_i |

## Verification
The single slice is driven exhaustively: every pair of nibbles under all eight cascade patterns.

- A slice that let the cascade inputs leak past a real bit difference would flip greater or less on ties it must ignore.
- A slice that decoded the two irregular patterns as "no result" would show all-zero outputs for 000 instead of both greater and less high.

The chain gets random operands and directed words that differ only in the lowest nibble or only in the highest bit. A chain wired in the wrong order, or with the least significant slice tied to the wrong pattern, fails on exactly those words. BCD operands around decade boundaries confirm that the comparison is weighted and unsigned.

// File: rtl/nibcmp_pkg.sv
package nibcmp_pkg;
  localparam int unsigned NIB_W = 4;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } cmp_flags_t;

  localparam cmp_flags_t FLAGS_EQ = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
endpackage

// File: rtl/nibcmp_bitcmp.sv
module nibcmp_bitcmp #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] gt_o,
  output logic [W-1:0] lt_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gt_o[i] = a_i[i] & ~b_i[i];
    assign lt_o[i] = ~a_i[i] & b_i[i];
  end
endmodule

// File: rtl/nibcmp_prio.sv
module nibcmp_prio #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] gt_i,
  input  logic [W-1:0] lt_i,
  output logic         gt_o,
  output logic         lt_o,
  output logic         tie_o
);
  // higher index overrides lower: first unequal pair from the MSB wins
  always_comb begin
    gt_o = 1'b0;
    lt_o = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (gt_i[i] | lt_i[i]) begin
        gt_o = gt_i[i];
        lt_o = lt_i[i];
      end
    end
  end

  assign tie_o = ~|(gt_i | lt_i);
endmodule

// File: rtl/nibcmp_slice.sv
module nibcmp_slice
  import nibcmp_pkg::*;
(
  input  logic [NIB_W-1:0] a_i,
  input  logic [NIB_W-1:0] b_i,
  input  logic             gt_i,
  input  logic             eq_i,
  input  logic             lt_i,
  output logic             gt_o,
  output logic             eq_o,
  output logic             lt_o
);
  logic [NIB_W-1:0] bit_gt, bit_lt;
  logic             p_gt, p_lt, tie;

  nibcmp_bitcmp #(.W(NIB_W)) i_bitcmp (
    .a_i (a_i),
    .b_i (b_i),
    .gt_o(bit_gt),
    .lt_o(bit_lt)
  );

  nibcmp_prio #(.W(NIB_W)) i_prio (
    .gt_i (bit_gt),
    .lt_i (bit_lt),
    .gt_o (p_gt),
    .lt_o (p_lt),
    .tie_o(tie)
  );

  // tie resolution: eq_i dominates; otherwise each side asserts unless the opposite is set
  cmp_flags_t tie_res;
  always_comb begin
    tie_res.eq = eq_i;
    tie_res.gt = ~eq_i & ~lt_i;
    tie_res.lt = ~eq_i & ~gt_i;
  end

  assign gt_o = tie ? tie_res.gt : p_gt;
  assign lt_o = tie ? tie_res.lt : p_lt;
  assign eq_o = tie & tie_res.eq;
endmodule

// File: rtl/nibcmp_chain.sv
module nibcmp_chain
  import nibcmp_pkg::*;
#(
  parameter int unsigned NSLICES = 3
) (
  input  logic [NIB_W*NSLICES-1:0] a_i,
  input  logic [NIB_W*NSLICES-1:0] b_i,
  output logic                     gt_o,
  output logic                     eq_o,
  output logic                     lt_o
);
  localparam int unsigned WORD_W = NIB_W * NSLICES;

  cmp_flags_t casc [NSLICES+1];

  assign casc[0] = FLAGS_EQ;

  for (genvar k = 0; k < NSLICES; k++) begin : g_slice
    nibcmp_slice i_slice (
      .a_i (a_i[k*NIB_W +: NIB_W]),
      .b_i (b_i[k*NIB_W +: NIB_W]),
      .gt_i(casc[k].gt),
      .eq_i(casc[k].eq),
      .lt_i(casc[k].lt),
      .gt_o(casc[k+1].gt),
      .eq_o(casc[k+1].eq),
      .lt_o(casc[k+1].lt)
    );
  end

  assign gt_o = casc[NSLICES].gt;
  assign eq_o = casc[NSLICES].eq;
  assign lt_o = casc[NSLICES].lt;

  if (WORD_W == 0) begin : g_bad
    $error("nibcmp_chain: NSLICES must be at least 1");
  end
endmodule

// File: rtl/nibcmp_chk.sv
module nibcmp_slice_chk (
  input logic [3:0] a_i,
  input logic [3:0] b_i,
  input logic       gt_i,
  input logic       eq_i,
  input logic       lt_i,
  input logic       gt_o,
  input logic       eq_o,
  input logic       lt_o
);
  always_comb begin
    if (!$isunknown({a_i, b_i, gt_i, eq_i, lt_i, gt_o, eq_o, lt_o})) begin
      if (a_i != b_i) begin
        // R1
        diff_decides_chk: assert (gt_o == (a_i > b_i) && lt_o == (a_i < b_i) && !eq_o)
          else $error("slice diff result wrong");
      end
      if (a_i == b_i && {gt_i, eq_i, lt_i} == 3'b100) begin
        // R2
        tie_gt_pass_chk: assert ({gt_o, eq_o, lt_o} == 3'b100) else $error("tie gt");
      end
      if (a_i == b_i && eq_i) begin
        // R3
        tie_eq_pass_chk: assert ({gt_o, eq_o, lt_o} == 3'b010) else $error("tie eq");
      end
      if (a_i == b_i && {gt_i, eq_i, lt_i} == 3'b101) begin
        // R4
        tie_both_low_chk: assert ({gt_o, eq_o, lt_o} == 3'b000) else $error("tie 101");
      end
      if (a_i == b_i && {gt_i, eq_i, lt_i} == 3'b000) begin
        // R5
        tie_none_high_chk: assert ({gt_o, eq_o, lt_o} == 3'b101) else $error("tie 000");
      end
      if ($onehot({gt_i, eq_i, lt_i})) begin
        // R6
        onehot_out_chk: assert ($onehot({gt_o, eq_o, lt_o})) else $error("not one-hot");
      end
    end
  end
endmodule

module nibcmp_chain_chk #(
  parameter int unsigned W = 12
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         gt_o,
  input logic         eq_o,
  input logic         lt_o
);
  always_comb begin
    if (!$isunknown({a_i, b_i, gt_o, eq_o, lt_o})) begin
      // R7
      word_order_chk: assert (gt_o == (a_i > b_i) && eq_o == (a_i == b_i) && lt_o == (a_i < b_i))
        else $error("chain result wrong");
    end
  end
endmodule

bind nibcmp_slice nibcmp_slice_chk i_slice_chk (
  .a_i (a_i),
  .b_i (b_i),
  .gt_i(gt_i),
  .eq_i(eq_i),
  .lt_i(lt_i),
  .gt_o(gt_o),
  .eq_o(eq_o),
  .lt_o(lt_o)
);

bind nibcmp_chain nibcmp_chain_chk #(.W(WORD_W)) i_chain_chk (
  .a_i (a_i),
  .b_i (b_i),
  .gt_o(gt_o),
  .eq_o(eq_o),
  .lt_o(lt_o)
);

// File: tb/test_nibcmp_chain.sv
`timescale 1ns/1ps
module test_nibcmp_chain;
  localparam int NS = 3;
  localparam int WW = 4 * NS;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]    sa = '0, sb = '0;
  logic [2:0]    sc = 3'b010;
  logic          s_gt, s_eq, s_lt;
  logic [WW-1:0] ca = '0, cb = '0;
  logic          c_gt, c_eq, c_lt;

  nibcmp_slice i_nibcmp_slice (
    .a_i(sa), .b_i(sb), .gt_i(sc[2]), .eq_i(sc[1]), .lt_i(sc[0]),
    .gt_o(s_gt), .eq_o(s_eq), .lt_o(s_lt)
  );

  nibcmp_chain #(.NSLICES(NS)) i_nibcmp_chain (
    .a_i(ca), .b_i(cb), .gt_o(c_gt), .eq_o(c_eq), .lt_o(c_lt)
  );

  typedef struct {
    bit       chain;
    bit       chk_onehot;
    logic [2:0] exp;
    string    req;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit drv_done = 0;

  function automatic logic [2:0] slice_ref(logic [3:0] a, logic [3:0] b, logic [2:0] c);
    if (a > b) return 3'b100;
    if (a < b) return 3'b001;
    if (c[1]) return 3'b010;
    case (c)
      3'b100:  return 3'b100;
      3'b001:  return 3'b001;
      3'b101:  return 3'b000;
      default: return 3'b101;
    endcase
  endfunction

  function automatic string slice_req(logic [3:0] a, logic [3:0] b, logic [2:0] c);
    if (a != b) return "R1";
    if (c[1]) return "R3";
    if (c == 3'b101) return "R4";
    if (c == 3'b000) return "R5";
    return "R2";
  endfunction

  task automatic push_slice(logic [3:0] a, logic [3:0] b, logic [2:0] c);
    item_t it;
    @(posedge clk);
    sa = a; sb = b; sc = c;
    it.chain = 0; it.exp = slice_ref(a, b, c); it.req = slice_req(a, b, c);
    it.chk_onehot = $onehot(c);
    q.push_back(it);
  endtask

  task automatic push_chain(logic [WW-1:0] a, logic [WW-1:0] b, string req);
    item_t it;
    @(posedge clk);
    ca = a; cb = b;
    it.chain = 1; it.chk_onehot = 0; it.req = req;
    it.exp = (a > b) ? 3'b100 : (a < b) ? 3'b001 : 3'b010;
    q.push_back(it);
  endtask

  function automatic logic [WW-1:0] to_bcd(int v);
    logic [WW-1:0] r = '0;
    for (int d = 0; d < NS; d++) begin
      r[4*d +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        logic [2:0] act;
        it = q.pop_front();
        act = it.chain ? {c_gt, c_eq, c_lt} : {s_gt, s_eq, s_lt};
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: %s act=%b exp=%b", it.req, it.chain ? "chain" : "slice", act, it.exp);
        end
        if (it.chk_onehot) begin
          total++;
          if ($countones(act) != 1 || $isunknown(act)) begin
            bad++;
            $display("FAIL R6: one-hot act=%b exp=one-hot", act);
          end
        end
      end
    end
  end

  // driver
  initial begin
    // idle state: equal operands must read as equal (R7)
    #1;
    total++;
    if ({c_gt, c_eq, c_lt} !== 3'b010) begin
      bad++;
      $display("FAIL R7: idle act=%b exp=010", {c_gt, c_eq, c_lt});
    end
    // exhaustive slice: R1..R6
    for (int c = 0; c < 8; c++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          push_slice(4'(a), 4'(b), 3'(c));
    // chain directed (R7): low nibble only, top bit only, all-ones
    push_chain(12'h001, 12'h000, "R7");
    push_chain(12'h000, 12'h001, "R7");
    push_chain(12'h800, 12'h7FF, "R7");
    push_chain(12'h7FF, 12'h800, "R7");
    push_chain(12'hFFF, 12'hFFF, "R7");
    push_chain(12'hA5F, 12'hA50, "R7");
    push_chain(12'h0F0, 12'h10F, "R7");
    // chain random (R7)
    for (int i = 0; i < 2000; i++) begin
      logic [WW-1:0] ra, rb;
      ra = WW'($urandom);
      rb = (i % 4 == 0) ? ra ^ WW'(1 << ($urandom % WW)) : WW'($urandom);
      if (i % 16 == 1) rb = ra;
      push_chain(ra, rb, "R7");
    end
    // BCD decade boundaries (R8)
    push_chain(to_bcd(99),  to_bcd(100), "R8");
    push_chain(to_bcd(109), to_bcd(90),  "R8");
    push_chain(to_bcd(999), to_bcd(998), "R8");
    push_chain(to_bcd(500), to_bcd(500), "R8");
    for (int i = 0; i < 200; i++)
      push_chain(to_bcd(int'($urandom % 1000)), to_bcd(int'($urandom % 1000)), "R8");
    repeat (3) @(posedge clk);
    drv_done = 1;
  end

  initial begin
    fork
      wait (drv_done && q.size() == 0);
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: act=timeout exp=done");
      end
    join_any
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule